// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Port Engine

This block is the device side of a synchronous SRAM port that moves two data words per access, one on each half of the reference clock period. It runs on a single clock at twice the reference rate. A phase flag that it generates itself marks which half is current: phase 0 is the half that starts at the reference rising edge, and phase 1 is the half that starts at the complementary edge. All timing below is counted in these half-cycles. "Cycle n" is the clock period whose closing edge samples the inputs.

A host issues a command in a phase-0 cycle by pulling the active-low load strobe low. The read/write select picks the operation. A write supplies its two data words, each with its own active-low byte masks, in the two half-cycles that start one full reference period after the command. A read returns its two words two and a half reference periods after the command. A valid flag and an output enable are raised only while those words are on the outputs. The second word of every burst always uses the partner address: the loaded address with its lowest bit inverted, so the burst wraps inside the pair.

Top module: `bsr_port_engine`

## Requirements
- R1: In the first cycle after a synchronous reset, `k_phase` is 0, `dout_valid` and `dout_en` are low, and `dout` is all zeros. A reset also drops any reads in flight.
- R2: `k_phase` inverts on every clock after reset. Phase 0 stands for the reference rising edge and phase 1 for the complementary edge.
- R3: A command is taken only when `ld_n` is low in a cycle with `k_phase` = 0. `rw` = 1 selects a read and `rw` = 0 a write. A low `ld_n` in a phase-1 cycle has no effect.
- R4: For a write taken in cycle n, `din` in cycle n+2 is stored at the loaded address and `din` in cycle n+3 at the partner address.
- R5: `bw_n` is sampled with each write word. Bit i of `bw_n` guards byte i of the word, which is bits 9i+8 down to 9i. A 0 stores that byte, and a 1 leaves the stored byte unchanged.
- R6: For a read taken in cycle n, `dout` carries the word at the loaded address in cycle n+5 and the word at the partner address in cycle n+6.
- R7: `dout_valid` and `dout_en` are high exactly in the cycles that carry read words. In every other cycle both are low and `dout` is zero.
- R8: When the loaded address is odd, the second word comes from the even address below it, so the burst wraps within the pair.
- R9: A read taken in the reference period right after a write to the same pair returns the new data. A read taken in the period just before a write returns the old data.
- R10: Reads taken in consecutive reference periods come out back to back, with `dout_valid` held high and no gap between the bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference rate |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 selects a read, 0 selects a write |
| addr | input | ADDR_W | Burst start address |
| din | input | N_BYTES*BYTE_W | Write data word |
| bw_n | input | N_BYTES | Active-low byte write masks |
| k_phase | output | 1 | Current half: 0 for the reference edge, 1 for the complementary edge |
| dout | output | N_BYTES*BYTE_W | Read data word, zero when not valid |
| dout_valid | output | 1 | Read data is on `dout` |
| dout_en | output | 1 | Output driver enable |

## Verification
A corrupted phase flag would move command acceptance to the wrong half. The first read after it would then show up one half-cycle early or late, or not at all, and `dout_valid` would rise in a phase-0 cycle. A wrong stage in a delay line would show on the ports as a read whose valid window starts off cycle n+5, or as a write word landing at the partner address. That becomes visible on the next read-back of the pair, at most six half-cycles after that read is issued. A fetch taken at the wrong moment breaks the ordering against an adjacent write: a read issued just before a write would return the new data, or a read just after it would return the old data.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } bsr_cmd_e;

  // Commands are only taken in the half that stands for the reference edge.
  function automatic bsr_cmd_e decode_cmd(input logic strobe_n, input logic rd_sel,
                                          input logic half);
    if (strobe_n || half) return CMD_IDLE;
    return rd_sel ? CMD_READ : CMD_WRITE;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              phase,
  output logic              rd_acc,
  output logic              wr_acc,
  output logic              wr_first,
  output logic              wr_second,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_fetch,
  output logic [ADDR_W-1:0] rd_addr
);
  import bsr_pkg::*;

  // Stage k of a delay line is live in cycle n+1+k for a command in cycle n.
  localparam int WR_BEAT0  = 1;
  localparam int WR_BEAT1  = 2;
  localparam int WR_STAGES = WR_BEAT1 + 1;
  localparam int RD_FETCH  = 3;
  localparam int RD_STAGES = RD_FETCH + 1;

  function automatic logic [ADDR_W-1:0] partner(input logic [ADDR_W-1:0] a);
    return a ^ ADDR_W'(1);
  endfunction

  bsr_cmd_e cmd;
  logic [WR_STAGES-1:0] wv;
  logic [ADDR_W-1:0]    wa [WR_STAGES];
  logic [RD_STAGES-1:0] rv;
  logic [ADDR_W-1:0]    ra [RD_STAGES];

  always_comb begin
    cmd    = rst ? CMD_IDLE : decode_cmd(ld_n, rw, phase);
    rd_acc = (cmd == CMD_READ);
    wr_acc = (cmd == CMD_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wv <= '0;
      rv <= '0;
    end else begin
      wv[0] <= wr_acc;
      rv[0] <= rd_acc;
      for (int i = 1; i < WR_STAGES; i++) wv[i] <= wv[i-1];
      for (int i = 1; i < RD_STAGES; i++) rv[i] <= rv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    wa[0] <= addr;
    ra[0] <= addr;
    for (int i = 1; i < WR_STAGES; i++) wa[i] <= wa[i-1];
    for (int i = 1; i < RD_STAGES; i++) ra[i] <= ra[i-1];
  end

  always_comb begin
    wr_first  = wv[WR_BEAT0];
    wr_second = wv[WR_BEAT1];
    wr_addr   = wr_first ? wa[WR_BEAT0] : partner(wa[WR_BEAT1]);
    rd_fetch  = rv[RD_FETCH];
    rd_addr   = ra[RD_FETCH];
  end

endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int ADDR_W  = 4,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [N_BYTES*BYTE_W-1:0] wr_data,
  input  logic [N_BYTES-1:0]        wr_mask_n,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [N_BYTES*BYTE_W-1:0] rd_word0,
  output logic [N_BYTES*BYTE_W-1:0] rd_word1
);
  localparam int DATA_W = N_BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                              input logic [DATA_W-1:0] new_w,
                                              input logic [N_BYTES-1:0] keep);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < N_BYTES; b++)
      if (!keep[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merge(mem[wr_addr], wr_data, wr_mask_n);
  end

  always_comb begin
    rd_word0 = mem[rd_addr];
    rd_word1 = mem[rd_addr ^ ADDR_W'(1)];
  end

endmodule

// File: rtl/bsr_rdout.sv
module bsr_rdout #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic [DATA_W-1:0] word0,
  input  logic [DATA_W-1:0] word1,
  output logic              second,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              dout_en
);
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      second     <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_en    <= 1'b0;
      hold       <= '0;
    end else if (fetch) begin
      dout       <= word0;
      hold       <= word1;
      second     <= 1'b1;
      dout_valid <= 1'b1;
      dout_en    <= 1'b1;
    end else if (second) begin
      dout       <= hold;
      second     <= 1'b0;
      dout_valid <= 1'b1;
      dout_en    <= 1'b1;
    end else begin
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_en    <= 1'b0;
    end
  end

endmodule

// File: rtl/bsr_port_engine.sv
module bsr_port_engine #(
  parameter int ADDR_W  = 4,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_n,
  input  logic                      rw,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_BYTES*BYTE_W-1:0] din,
  input  logic [N_BYTES-1:0]        bw_n,
  output logic                      k_phase,
  output logic [N_BYTES*BYTE_W-1:0] dout,
  output logic                      dout_valid,
  output logic                      dout_en
);
  localparam int DATA_W = N_BYTES * BYTE_W;

  logic              rd_acc, wr_acc, wr_first, wr_second, rd_fetch, rd_second;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_word0, rd_word1;

  bsr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr),
    .phase(k_phase), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .wr_first(wr_first), .wr_second(wr_second), .wr_addr(wr_addr),
    .rd_fetch(rd_fetch), .rd_addr(rd_addr)
  );

  bsr_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_array (
    .clk(clk), .wr_en(wr_first | wr_second), .wr_addr(wr_addr),
    .wr_data(din), .wr_mask_n(bw_n), .rd_addr(rd_addr),
    .rd_word0(rd_word0), .rd_word1(rd_word1)
  );

  bsr_rdout #(.DATA_W(DATA_W)) u_rdout (
    .clk(clk), .rst(rst), .fetch(rd_fetch), .word0(rd_word0), .word1(rd_word1),
    .second(rd_second), .dout(dout), .dout_valid(dout_valid), .dout_en(dout_en)
  );

endmodule

// File: rtl/bsr_port_engine_chk.sv
module bsr_port_engine_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              k_phase,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic              dout_en,
  input logic              rd_acc,
  input logic              wr_acc,
  input logic              wr_first,
  input logic              wr_second,
  input logic              rd_fetch,
  input logic              rd_second
);
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (k_phase != $past(k_phase)));

  p_cmd_half_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_acc || wr_acc) |-> !k_phase);

  p_wr_beat0_r4: assert property (@(posedge clk) disable iff (rst)
    $past(wr_acc, 2) |-> (wr_first && !k_phase));

  p_wr_beat1_r4: assert property (@(posedge clk) disable iff (rst)
    wr_first |=> wr_second);

  p_rd_latency_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rd_acc, 5) |-> dout_valid);

  p_en_tracks_valid_r7: assert property (@(posedge clk) disable iff (rst)
    dout_en == dout_valid);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> (dout == '0));

  p_valid_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_valid) |-> k_phase);

  p_beat_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_fetch, rd_second}));

endmodule

bind bsr_port_engine bsr_port_engine_chk #(.DATA_W(N_BYTES*BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .k_phase(k_phase), .dout(dout), .dout_valid(dout_valid),
  .dout_en(dout_en), .rd_acc(rd_acc), .wr_acc(wr_acc), .wr_first(wr_first),
  .wr_second(wr_second), .rd_fetch(rd_fetch), .rd_second(rd_second)
);

// File: tb/bsr_port_engine_bench.sv
module bsr_port_engine_bench;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int NB = 2;
  localparam int OP_NOP = 0, OP_RD = 1, OP_WR = 2;
  localparam int ROW_W = 2 + AW + DW + NB + DW + NB;
  localparam int N_ROWS = 12;
  // row: op, addr, data/mask pair for the previous row's write
  localparam logic [ROW_W-1:0] TBL [N_ROWS] = '{
    {2'd2, 4'd5, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd1, 4'd5, 18'h15A5A, 2'b00, 18'h0F0F0, 2'b00},
    {2'd2, 4'd2, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd0, 4'd0, 18'h3FFFF, 2'b01, 18'h12345, 2'b10},
    {2'd1, 4'd2, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd1, 4'd6, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd2, 4'd6, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd1, 4'd7, 18'h2AAAA, 2'b10, 18'h01111, 2'b00},
    {2'd0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {2'd0, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_n = 1'b1, rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [NB-1:0] bw_n = '1;
  logic k_phase, dout_valid, dout_en;
  logic [DW-1:0] dout;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] mdl [16];
  bit            ev [8];
  logic [DW-1:0] ed [8];
  bit            rv [8];
  logic [AW-1:0] ra [8];
  bit            wv [8];
  logic [AW-1:0] wa [8];

  always #4 clk = ~clk;

  bsr_port_engine u_bsr_port_engine (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr), .din(din), .bw_n(bw_n),
    .k_phase(k_phase), .dout(dout), .dout_valid(dout_valid), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at half-cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) begin ev[i] = 0; rv[i] = 0; wv[i] = 0; end
    cyc = 0;
  endtask

  // One half-cycle, entered at a falling edge: check, update model, drive, wait.
  task automatic half(input string tag, input logic l, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] b);
    int s;
    s = cyc % 8;
    chk("R2 phase", 32'(k_phase), 32'(cyc % 2));
    chk(tag, 32'(dout_valid), 32'(ev[s]));
    chk(tag, 32'(dout_en), 32'(ev[s]));
    chk(tag, 32'(dout), ev[s] ? 32'(ed[s]) : 32'd0);
    ev[s] = 0;
    if (rv[(cyc + 4) % 8]) begin
      ev[(cyc + 1) % 8] = 1; ed[(cyc + 1) % 8] = mdl[ra[(cyc + 4) % 8]];
      ev[(cyc + 2) % 8] = 1; ed[(cyc + 2) % 8] = mdl[ra[(cyc + 4) % 8] ^ 4'd1];
      rv[(cyc + 4) % 8] = 0;
    end
    if (wv[s]) begin
      for (int k = 0; k < NB; k++)
        if (!b[k]) mdl[wa[s]][k*9 +: 9] = d[k*9 +: 9];
      wv[s] = 0;
    end
    ld_n = l; rw = r; addr = a; din = d; bw_n = b;
    if (!l && (cyc % 2 == 0)) begin
      if (r) begin rv[s] = 1; ra[s] = a; end
      else begin
        wv[(cyc + 2) % 8] = 1; wa[(cyc + 2) % 8] = a;
        wv[(cyc + 3) % 8] = 1; wa[(cyc + 3) % 8] = a ^ 4'd1;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic kc(input string tag, input int op, input logic [AW-1:0] a,
                    input logic [DW-1:0] d0, input logic [NB-1:0] b0,
                    input logic [DW-1:0] d1, input logic [NB-1:0] b1);
    half(tag, (op == OP_NOP), (op == OP_RD), a, d0, b0);
    half(tag, 1'b1, 1'b0, '0, d1, b1);
  endtask

  task automatic do_reset();
    rst = 1'b1; ld_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_model();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(32'h0A000 + a * 32'h0111);
  endfunction

  initial begin
    clear_model();
    do_reset();
    // R1: reset state in the first cycle after release
    chk("R1 phase", 32'(k_phase), 32'd0);
    chk("R1 valid", 32'(dout_valid), 32'd0);
    chk("R1 enable", 32'(dout_en), 32'd0);
    chk("R1 data", 32'(dout), 32'd0);

    // R4: fill every pair, each write's data in the following reference period
    for (int a = 0; a < 16; a += 2)
      kc("R4 fill", OP_WR, 4'(a), (a == 0) ? '0 : pat(a - 2), (a == 0) ? 2'b11 : 2'b00,
         (a == 0) ? '0 : pat(a - 1), (a == 0) ? 2'b11 : 2'b00);
    kc("R4 fill", OP_NOP, '0, pat(14), 2'b00, pat(15), 2'b00);
    // R6 R10: read back every pair in consecutive periods
    for (int a = 0; a < 16; a += 2) kc("R6 R10 readback", OP_RD, 4'(a), '0, 2'b11, '0, 2'b11);
    for (int i = 0; i < 4; i++) kc("R7 drain", OP_NOP, '0, '0, 2'b11, '0, 2'b11);

    // R5 R8 R9 R10 table
    for (int i = 0; i < N_ROWS; i++) begin
      logic [ROW_W-1:0] row;
      row = TBL[i];
      kc("R5 R8 R9 R10 table", int'(row[ROW_W-1 -: 2]), row[ROW_W-3 -: AW],
         row[2*DW+2*NB-1 -: DW], row[DW+2*NB-1 -: NB], row[DW+NB-1 -: DW], row[NB-1:0]);
    end

    // R3: a load in phase 1 is ignored
    half("R3 ignore", 1'b1, 1'b0, '0, '0, 2'b11);
    half("R3 ignore", 1'b0, 1'b1, 4'd4, '0, 2'b11);
    for (int i = 0; i < 5; i++) kc("R3 ignore", OP_NOP, '0, '0, 2'b11, '0, 2'b11);

    // R1: reset in the middle of a read drops it
    kc("R1 pre", OP_RD, 4'd9, '0, 2'b11, '0, 2'b11);
    kc("R1 pre", OP_NOP, '0, '0, 2'b11, '0, 2'b11);
    do_reset();
    for (int i = 0; i < 4; i++) kc("R1 dropped read", OP_NOP, '0, '0, 2'b11, '0, 2'b11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule